// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit sits beside the instruction sequencer of an 8-bit microcontroller core that has a 16-bit address space. The decoder has already classified the instruction. From that decoded addressing mode, the operand bytes that follow the opcode, the current program counter and the two index registers, the unit works out three things: the operand's effective address, the byte length of the instruction, and the program counter of the next instruction. All three come out of registers one clock after the inputs are presented.

Six modes are covered. Immediate points at the byte after the opcode. Direct addresses the first 256 bytes. Extended carries a full 16-bit address. Indexed adds an unsigned offset to either index register. Inherent has no memory operand. Relative forms a conditional branch target. An optional prebyte in front of the opcode makes every instruction one byte longer. For conditional branches the unit also settles the branch: it selects either the target or the fall-through address.

Top module: `eag_top`

## Requirements
- R1: The mode code is 3 bits: 0 immediate, 1 direct, 2 extended, 3 indexed, 4 inherent, 5 relative, and 6 and 7 are reserved and act as inherent. Every output is registered with a latency of exactly one clock. While `rst` is high at a clock edge, `ea`, `next_pc`, `ilen` and `ea_ok` are all cleared to zero.
- R2: In direct mode, `ea` is 0x00 in the high byte and `opnd_a` in the low byte. The length is 2 bytes.
- R3: In extended mode, `ea` is `{opnd_a, opnd_b}`, with `opnd_a` as the high byte. The length is 3 bytes.
- R4: In indexed mode, `ea` is the selected index register plus `opnd_a` zero-extended, taken modulo 65536. The register is `iy` when `sel_iy` is 1 and `ix` otherwise. The length is 2 bytes.
- R5: In relative mode, the length is 2 bytes and `ea` is `pc + ilen + sign-extended opnd_a`, taken modulo 65536. `next_pc` equals `ea` when `br_taken` is 1 and `pc + ilen` when it is 0.
- R6: In immediate mode, `ea` is `pc + 1 + prebyte`, which is the first byte after the opcode. The length is 1 + prebyte + data bytes, where data bytes is 2 when `imm_wide` is 1 and 1 otherwise.
- R7: In inherent mode and in the reserved codes, `ea_ok` is 0 and `ea` is 0. The length is 1 byte. In every other mode, `ea_ok` is 1.
- R8: When `prebyte` is 1, `ilen` is one more than the mode's base length, in every mode.
- R9: In every mode except relative, `next_pc` is `pc + ilen` modulo 65536.
- R10: `sel_iy` has no effect outside indexed mode, and `br_taken` and `imm_wide` have no effect outside relative and immediate mode respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Decoded addressing mode code |
| prebyte | input | 1 | Opcode is preceded by a prebyte |
| sel_iy | input | 1 | Indexed mode uses IY instead of IX |
| br_taken | input | 1 | Branch condition is true |
| imm_wide | input | 1 | Immediate data is two bytes |
| pc | input | 16 | Address of the instruction's first byte |
| opnd_a | input | 8 | First byte after the opcode |
| opnd_b | input | 8 | Second byte after the opcode |
| ix | input | 16 | Index register X |
| iy | input | 16 | Index register Y |
| ea | output | 16 | Effective operand address |
| ea_ok | output | 1 | Instruction has a memory effective address |
| next_pc | output | 16 | Address of the next instruction |
| ilen | output | 3 | Instruction length in bytes |

## Verification
The assertions check several properties on every cycle against a registered copy of the inputs. Direct-mode results stay inside the first page. Inherent and reserved codes never claim an address. The length always falls between 1 and 4. A branch that is not taken lands exactly on the next sequential instruction, and relative mode always has length 2 plus the prebyte. Only the bench's sweeps can show that the arithmetic is right. That covers wrap-around of index sums and branch targets at the top of memory, negative branch offsets, IX versus IY selection, and the absence of any effect from the control inputs that a mode ignores.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_DIR  = 3'd1,
    AM_EXT  = 3'd2,
    AM_IDX  = 3'd3,
    AM_INH  = 3'd4,
    AM_REL  = 3'd5,
    AM_RSV6 = 3'd6,
    AM_RSV7 = 3'd7
  } amode_t;

  localparam int LEN_W = 3;
endpackage

// File: rtl/eag_len.sv
module eag_len
  import eag_pkg::*;
(
  input  amode_t             mode,
  input  logic               prebyte,
  input  logic               imm_wide,
  output logic [LEN_W-1:0]   len
);
  logic [LEN_W-1:0] base;

  always_comb begin
    case (mode)
      AM_IMM:  base = imm_wide ? LEN_W'(3) : LEN_W'(2);
      AM_DIR:  base = LEN_W'(2);
      AM_EXT:  base = LEN_W'(3);
      AM_IDX:  base = LEN_W'(2);
      AM_REL:  base = LEN_W'(2);
      default: base = LEN_W'(1);
    endcase
    len = base + LEN_W'(prebyte);
  end
endmodule

// File: rtl/eag_addr.sv
module eag_addr
  import eag_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  amode_t             mode,
  input  logic               prebyte,
  input  logic               sel_iy,
  input  logic               br_taken,
  input  logic [AW-1:0]      pc,
  input  logic [DW-1:0]      opnd_a,
  input  logic [DW-1:0]      opnd_b,
  input  logic [AW-1:0]      ix,
  input  logic [AW-1:0]      iy,
  input  logic [LEN_W-1:0]   len,
  output logic [AW-1:0]      ea,
  output logic               ea_ok,
  output logic [AW-1:0]      next_pc
);
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] idx_base;
  logic [AW-1:0] off_zx;
  logic [AW-1:0] off_sx;
  logic [AW-1:0] br_tgt;

  assign seq_pc   = pc + AW'(len);
  assign idx_base = sel_iy ? iy : ix;
  assign off_zx   = {{(AW-DW){1'b0}}, opnd_a};
  assign off_sx   = {{(AW-DW){opnd_a[DW-1]}}, opnd_a};
  assign br_tgt   = seq_pc + off_sx;

  always_comb begin
    ea      = '0;
    ea_ok   = 1'b1;
    next_pc = seq_pc;
    case (mode)
      AM_IMM: ea = pc + AW'(1) + AW'(prebyte);
      AM_DIR: ea = off_zx;
      AM_EXT: ea = {opnd_a, opnd_b};
      AM_IDX: ea = idx_base + off_zx;
      AM_REL: begin
        ea      = br_tgt;
        next_pc = br_taken ? br_tgt : seq_pc;
      end
      default: ea_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             prebyte,
  input  logic             sel_iy,
  input  logic             br_taken,
  input  logic             imm_wide,
  input  logic [AW-1:0]    pc,
  input  logic [DW-1:0]    opnd_a,
  input  logic [DW-1:0]    opnd_b,
  input  logic [AW-1:0]    ix,
  input  logic [AW-1:0]    iy,
  output logic [AW-1:0]    ea,
  output logic             ea_ok,
  output logic [AW-1:0]    next_pc,
  output logic [LEN_W-1:0] ilen
);
  amode_t            mode_e;
  logic [LEN_W-1:0]  len_c;
  logic [AW-1:0]     ea_c;
  logic              ok_c;
  logic [AW-1:0]     npc_c;

  assign mode_e = amode_t'(mode);

  eag_len u_len (
    .mode     (mode_e),
    .prebyte  (prebyte),
    .imm_wide (imm_wide),
    .len      (len_c)
  );

  eag_addr #(.DW(DW)) u_addr (
    .mode     (mode_e),
    .prebyte  (prebyte),
    .sel_iy   (sel_iy),
    .br_taken (br_taken),
    .pc       (pc),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .ix       (ix),
    .iy       (iy),
    .len      (len_c),
    .ea       (ea_c),
    .ea_ok    (ok_c),
    .next_pc  (npc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea      <= '0;
      ea_ok   <= 1'b0;
      next_pc <= '0;
      ilen    <= '0;
    end else begin
      ea      <= ea_c;
      ea_ok   <= ok_c;
      next_pc <= npc_c;
      ilen    <= len_c;
    end
  end

  // Registered copy of the inputs the checks relate the outputs to
  amode_t        mode_q;
  logic          pre_q;
  logic          taken_q;
  logic [AW-1:0] pc_q;
  logic          primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= AM_INH;
      pre_q   <= 1'b0;
      taken_q <= 1'b0;
      pc_q    <= '0;
      primed  <= 1'b0;
    end else begin
      mode_q  <= mode_e;
      pre_q   <= prebyte;
      taken_q <= br_taken;
      pc_q    <= pc;
      primed  <= 1'b1;
    end
  end

  // R2: a direct-mode result never leaves the first page
  a_r2_zero_page: assert property (@(posedge clk) disable iff (rst)
    (primed && mode_q == AM_DIR) |-> (ea[AW-1:DW] == '0));

  // R7: inherent and reserved codes claim no address
  a_r7_no_ea: assert property (@(posedge clk) disable iff (rst)
    (primed && (mode_q == AM_INH || mode_q == AM_RSV6 || mode_q == AM_RSV7))
      |-> (!ea_ok && ea == '0));

  // R8: length stays within one to four bytes
  a_r8_len_range: assert property (@(posedge clk) disable iff (rst)
    primed |-> (ilen >= LEN_W'(1) && ilen <= LEN_W'(4)));

  // R5: untaken branch falls through past the whole instruction
  a_r5_fall_through: assert property (@(posedge clk) disable iff (rst)
    (primed && mode_q == AM_REL && !taken_q) |-> (next_pc == pc_q + AW'(ilen)));

  // R5: a branch is two bytes plus the prebyte
  a_r5_rel_len: assert property (@(posedge clk) disable iff (rst)
    (primed && mode_q == AM_REL) |-> (ilen == LEN_W'(2) + LEN_W'(pre_q)));
endmodule

// File: tb/test_eag_top.sv
module test_eag_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode = '0;
  logic        prebyte = 1'b0, sel_iy = 1'b0, br_taken = 1'b0, imm_wide = 1'b0;
  logic [15:0] pc = '0, ix = '0, iy = '0;
  logic [7:0]  opnd_a = '0, opnd_b = '0;
  logic [15:0] ea, next_pc;
  logic        ea_ok;
  logic [2:0]  ilen;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  eag_top i_eag_top (
    .clk(clk), .rst(rst), .mode(mode), .prebyte(prebyte), .sel_iy(sel_iy),
    .br_taken(br_taken), .imm_wide(imm_wide), .pc(pc), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .ix(ix), .iy(iy), .ea(ea), .ea_ok(ea_ok),
    .next_pc(next_pc), .ilen(ilen)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int m);
    case (m)
      0: return "R6";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      5: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic set_data(input int d);
    case (d)
      0: begin pc = 16'h1000; opnd_a = 8'h34; opnd_b = 8'h12; ix = 16'h2000; iy = 16'h3000; end
      1: begin pc = 16'hFFFE; opnd_a = 8'h80; opnd_b = 8'hFF; ix = 16'hFFF0; iy = 16'hFF80; end
      2: begin pc = 16'h0000; opnd_a = 8'hFF; opnd_b = 8'h00; ix = 16'h0000; iy = 16'hFFFF; end
      3: begin pc = 16'h00F0; opnd_a = 8'h7F; opnd_b = 8'hAB; ix = 16'h1234; iy = 16'hABCD; end
      4: begin pc = 16'h8000; opnd_a = 8'h00; opnd_b = 8'hCD; ix = 16'h7FFF; iy = 16'h0001; end
      default: begin pc = 16'hFFFC; opnd_a = 8'h01; opnd_b = 8'h5A; ix = 16'hFF01; iy = 16'hFFFE; end
    endcase
  endtask

  initial begin
    int unsigned wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] e_ea, e_npc, tgt;
    logic [2:0]  e_len;
    logic        e_ok;
    int          pre;
    // R1: reset clears every output
    set_data(0);
    mode = 3'd2;
    repeat (3) @(negedge clk);
    chk("R1", "reset ea", int'(ea), 0);
    chk("R1", "reset next_pc", int'(next_pc), 0);
    chk("R1", "reset ilen", int'(ilen), 0);
    chk("R1", "reset ea_ok", int'(ea_ok), 0);
    rst = 1'b0;

    for (int d = 0; d < 6; d++) begin
      for (int m = 0; m < 8; m++) begin
        for (int k = 0; k < 16; k++) begin
          @(negedge clk);
          set_data(d);
          mode = 3'(m);
          prebyte = k[0]; sel_iy = k[1]; br_taken = k[2]; imm_wide = k[3];
          pre = k[0] ? 1 : 0;
          e_ok = 1'b1;
          e_ea = 16'h0000;
          case (m)
            0: begin e_len = 3'(1 + pre + (k[3] ? 2 : 1)); e_ea = pc + 16'(1 + pre); end
            1: begin e_len = 3'(2 + pre); e_ea = {8'h00, opnd_a}; end
            2: begin e_len = 3'(3 + pre); e_ea = {opnd_a, opnd_b}; end
            3: begin e_len = 3'(2 + pre); e_ea = (k[1] ? iy : ix) + {8'h00, opnd_a}; end
            5: begin e_len = 3'(2 + pre); e_ea = pc + 16'(e_len) + {{8{opnd_a[7]}}, opnd_a}; end
            default: begin e_len = 3'(1 + pre); e_ok = 1'b0; end
          endcase
          tgt = pc + 16'(e_len);
          e_npc = (m == 5 && k[2]) ? e_ea : tgt;
          // R1: one-cycle latency; results sampled at the next falling edge
          @(negedge clk);
          chk(req_of(m), "ea", int'(ea), int'(e_ea));
          chk("R7", "ea_ok", int'(ea_ok), int'(e_ok));
          chk(pre == 1 ? "R8" : req_of(m), "ilen", int'(ilen), int'(e_len));
          chk(m == 5 ? "R5" : "R9", "next_pc", int'(next_pc), int'(e_npc));
          // R10: outputs above are compared in full for every combination of
          // sel_iy, br_taken and imm_wide, so an unused control changing a result fails
        end
      end
    end

    // R1: reset applied mid-stream clears outputs again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "re-reset ea", int'(ea), 0);
    chk("R1", "re-reset ilen", int'(ilen), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule